// File: doc/BRIEF.md
# CAN bit timing unit

This block turns the system clock into the bit timing of a CAN node. A 15-bit configuration word sets three things: the prescaler, which divides the clock into time quanta; the lengths of the two phase segments; and the largest phase correction allowed on each edge. A nominal bit has three parts in this order: a one-quantum sync segment, a segment before the sample point, and a segment after it. The block produces two single-cycle strobes. The sample strobe marks the sample point and the bit-end strobe marks the bit boundary. Both follow recessive-to-dominant edges on the receive line.

The configuration can be changed only while the node is in initialization and configuration changes are enabled. While initialization is active, the timing counters are held at the start of a bit. After initialization the node treats the bus as idle. A falling edge on an idle bus restarts the bit (hard synchronization). A falling edge during traffic moves the sample point or the bit boundary by a limited amount (resynchronization). The bus becomes idle again after a run of recessive samples.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the configuration reads 0x00002301: prescaler field 1, pre-sample field 3, post-sample field 2, jump field 0.
- R2: Read bits 31:15 are always zero, and write data in those bits is discarded.
- R3: A write (cfg_wr high at a clock edge) updates the configuration only when init_en and cfg_chg_en are both high. Otherwise the stored value is unchanged.
- R4: The prescaler field in bits 5:0 gives P = field+1 clocks per quantum. The pre-sample field in bits 11:8 gives S = field+1 quanta, and the post-sample field in bits 14:12 gives T = field+1 quanta. With no edges on rx, bit_end pulses every N·P clocks, where N = 1+S+T.
- R5: The sample strobe pulses on the last clock of quantum index S of each bit (index 0 is sync), so it comes (S+1)·P clocks after the bit starts. It never coincides with bit_end.
- R6: rx is 1 for recessive and 0 for dominant. While the bus is idle, a falling edge of rx (1 in one clock, 0 in the next) starts a new bit on the next clock: sample at (S+1)·P clocks and bit_end at N·P clocks after the edge clock. The bus is idle after init and again after IDLE_BITS (default 11) consecutive sample points that see rx = 1.
- R7: The jump field in bits 7:6 gives J = field+1. Outside idle, a falling edge in quantum q with 1 ≤ q ≤ S delays both the sample strobe and bit_end by min(q, J) quanta.
- R8: Outside idle, a falling edge in quantum q after the sample point moves bit_end earlier by min(L−q, J) quanta, where L = N−1 is the last quantum index. The bit never ends before the quantum that holds the edge.
- R9: An edge in the sync quantum has no effect. Only the first resynchronizing edge in a bit acts; later edges in the same bit are ignored.
- R10: While init_en is high, no strobe is produced. The clock on which init_en falls is the first clock of a sync quantum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| init_en | input | 1 | Initialization mode; holds the timing counters |
| cfg_chg_en | input | 1 | Configuration change enable |
| rx | input | 1 | Receive line, 1 = recessive |
| sample_pulse | output | 1 | Sample point strobe |
| bit_end | output | 1 | Bit boundary strobe |

## Verification
The free-running timing is swept over every pre-sample and post-sample value at two prescaler settings. This separates an off-by-one in each field and shows whether quanta are counted in clocks or in quanta. Falling edges are placed in every quantum of a bit, for every jump width. This splits the sync, pre-sample and post-sample cases and checks that the correction stops at the jump-width limit. Two further patterns check the remaining rules. Double edges and edges in the sync quantum show that only one resynchronization acts per bit. The same edge phase is applied after ten and after eleven recessive samples, so resynchronization and hard synchronization must give different results.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter logic [14:0] RESET_CFG = 15'h2301,
  parameter int          IDLE_BITS = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        init_en,
  input  logic        cfg_chg_en,
  input  logic        rx,
  output logic        sample_pulse,
  output logic        bit_end
);
  localparam int IW = $clog2(IDLE_BITS + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_BITS - 1);

  logic [14:0] cfg;
  logic [5:0]  pcnt;
  logic [4:0]  q, ext, shr;
  logic        resynced, idle, rx_q;
  logic [IW-1:0] rec_cnt;
  logic        unused_hi;

  wire [5:0] brp = cfg[5:0];
  wire [1:0] sjw = cfg[7:6];
  wire [3:0] t1  = cfg[11:8];
  wire [2:0] t2  = cfg[14:12];

  assign cfg_rdata = {17'd0, cfg};
  assign unused_hi = ^cfg_wdata[31:15];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cfg <= RESET_CFG;
    else if (cfg_wr && init_en && cfg_chg_en) cfg <= cfg_wdata[14:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx;

  wire       tick      = (pcnt == brp);
  wire       edge_seen = rx_q & ~rx;
  wire       hard      = !init_en && idle && edge_seen;
  wire       rs_ok     = !init_en && !idle && !resynced && edge_seen && (q != 5'd0);
  wire [4:0] jw        = {3'd0, sjw} + 5'd1;
  wire [4:0] s_nom     = {1'b0, t1} + 5'd1;
  wire [4:0] spt       = s_nom + ext;
  wire       in_pre    = (q <= spt);
  wire [4:0] l_cur     = spt + {2'd0, t2} + 5'd1 - shr;
  wire [4:0] early     = l_cur - q;

  wire [4:0] ext_n = (rs_ok && in_pre)  ? ((q < jw) ? q : jw)         : ext;
  wire [4:0] shr_n = (rs_ok && !in_pre) ? ((early < jw) ? early : jw) : shr;
  wire [4:0] spt_n = s_nom + ext_n;
  wire [4:0] end_n = spt_n + {2'd0, t2} + 5'd1 - shr_n;

  assign sample_pulse = !init_en && !hard && tick && (q == spt_n);
  assign bit_end      = !init_en && !hard && tick && (q == end_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; q <= '0; ext <= '0; shr <= '0;
      resynced <= 1'b0; idle <= 1'b1; rec_cnt <= '0;
    end else if (init_en || hard) begin
      pcnt <= '0; q <= '0; ext <= '0; shr <= '0;
      resynced <= 1'b0; idle <= init_en; rec_cnt <= '0;
    end else begin
      ext <= ext_n;
      shr <= shr_n;
      if (rs_ok) resynced <= 1'b1;
      pcnt <= tick ? 6'd0 : pcnt + 6'd1;
      if (tick) begin
        if (bit_end) begin
          q <= '0; ext <= '0; shr <= '0; resynced <= 1'b0;
        end else begin
          q <= q + 5'd1;
        end
      end
      if (sample_pulse) begin
        if (!rx)                        rec_cnt <= '0;
        else if (rec_cnt == IDLE_LAST)  idle <= 1'b1;
        else                            rec_cnt <= rec_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        init_en,
  input logic        cfg_chg_en,
  input logic [31:0] cfg_rdata,
  input logic        sample_pulse,
  input logic        bit_end
);
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && init_en && cfg_chg_en) |=> $stable(cfg_rdata));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:15] == 17'd0);

  p_init_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_en |-> (!sample_pulse && !bit_end));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pulse && bit_end));

  p_end_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !bit_end);
endmodule

bind can_bit_timer can_bit_timer_chk chk_i (.*);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        init_en = 1'b1;
  logic        cfg_chg_en = 1'b0;
  logic        rx = 1'b1;
  logic        sample_pulse, bit_end;

  int cyc = 0;
  int tests = 0, fails = 0;
  int st[8], et[8];
  int ns, ne;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    ns = 0; ne = 0;
    for (int i = 0; i < 8; i++) begin st[i] = -1; et[i] = -1; end
  endtask

  task automatic step();
    @(negedge clk);
    if (sample_pulse) begin if (ns < 8) st[ns] = cyc; ns++; end
    if (bit_end)      begin if (ne < 8) et[ne] = cyc; ne++; end
    @(posedge clk); #1;
  endtask

  task automatic run_to(input int c);
    while (cyc < c) step();
  endtask

  task automatic configure(input logic [31:0] w, output int t0);
    init_en = 1'b1; cfg_chg_en = 1'b1; cfg_wr = 1'b1; cfg_wdata = w; rx = 1'b1;
    tick_();
    cfg_wr = 1'b0; cfg_chg_en = 1'b0;
    tick_();
    init_en = 1'b0;
    t0 = cyc;
  endtask

  task automatic hsync(output int c);
    rx = 1'b0; c = cyc; clr(); step(); rx = 1'b1;
  endtask

  function automatic logic [31:0] word(input int brp, input int sj, input int a, input int d);
    return 32'(brp) | (32'(sj) << 6) | (32'(a) << 8) | (32'(d) << 12);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, c, n, p, s, jj, e, ex;
    repeat (3) tick_();
    rst_n = 1'b1;
    tick_();
    chk(cfg_rdata == 32'h0000_2301, "R1 reset value", int'(cfg_rdata), 32'h2301);
    clr(); repeat (40) step();
    chk(ns == 0 && ne == 0, "R10 strobes during init", ns + ne, 0);

    cfg_chg_en = 1; cfg_wr = 1; cfg_wdata = 32'hFFFF_FFFF; tick_(); cfg_wr = 0;
    chk(cfg_rdata == 32'h0000_7FFF, "R2 reserved bits dropped", int'(cfg_rdata), 32'h7FFF);
    cfg_chg_en = 0; cfg_wr = 1; cfg_wdata = 32'h1234_5678; tick_(); cfg_wr = 0;
    chk(cfg_rdata == 32'h0000_7FFF, "R3 write without change enable", int'(cfg_rdata), 32'h7FFF);
    init_en = 0; cfg_chg_en = 1; cfg_wr = 1; cfg_wdata = 32'h0000_0000; tick_(); cfg_wr = 0;
    chk(cfg_rdata == 32'h0000_7FFF, "R3 write without init", int'(cfg_rdata), 32'h7FFF);
    init_en = 1; cfg_wr = 1; cfg_wdata = 32'hABCD_1234; tick_(); cfg_wr = 0; cfg_chg_en = 0;
    chk(cfg_rdata == 32'h0000_1234, "R2 R3 enabled write", int'(cfg_rdata), 32'h1234);

    // R4 R5 free-running sweep
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 16; a++)
        for (int d = 0; d < 8; d++) begin
          p = (b == 0) ? 1 : 3;
          n = 3 + a + d;
          configure(word(p - 1, 0, a, d), t0);
          clr();
          run_to(t0 + 2 * n * p + 2);
          chk(et[0] == t0 + n * p - 1 && et[1] == t0 + 2 * n * p - 1,
              "R4 bit period", et[1] - et[0], n * p);
          chk(st[0] == t0 + (a + 2) * p - 1 && st[1] == st[0] + n * p,
              "R5 sample point", st[0] - t0, (a + 2) * p - 1);
        end

    // R10 init mid-run stops strobes
    configure(word(1, 0, 3, 2), t0);
    repeat (30) step();
    init_en = 1; clr(); repeat (30) step();
    chk(ns == 0 && ne == 0, "R10 init mid-run", ns + ne, 0);

    // R6 hard sync at several phases
    for (int off = 0; off < 16; off++) begin
      configure(word(1, 0, 3, 2), t0);
      run_to(t0 + 3 + off);
      hsync(c);
      run_to(c + 20);
      chk(st[0] == c + 10 && et[0] == c + 16, "R6 hard sync", et[0] - c, 16);
    end

    // R7 pre-sample resync; P=2, S=6, T=5, N=12
    for (int sj = 0; sj < 4; sj++)
      for (int qq = 1; qq <= 6; qq++) begin
        jj = sj + 1;
        ex = (qq < jj) ? qq : jj;
        configure(word(1, sj, 5, 4), t0);
        run_to(t0 + 3);
        hsync(c);
        run_to(c + 1 + qq * 2 + (qq % 2));
        rx = 0; step(); rx = 1;
        run_to(c + 36);
        chk(st[0] == c + (7 + ex) * 2 && et[0] == c + (12 + ex) * 2,
            "R7 lengthen", et[0] - c, (12 + ex) * 2);
      end

    // R8 post-sample resync
    for (int sj = 0; sj < 4; sj++)
      for (int qq = 7; qq <= 11; qq++) begin
        jj = sj + 1;
        ex = ((11 - qq) < jj) ? (11 - qq) : jj;
        configure(word(1, sj, 5, 4), t0);
        run_to(t0 + 3);
        hsync(c);
        run_to(c + 1 + qq * 2 + (qq % 2));
        rx = 0; step(); rx = 1;
        run_to(c + 30);
        chk(st[0] == c + 14 && et[0] == c + (12 - ex) * 2,
            "R8 shorten", et[0] - c, (12 - ex) * 2);
      end

    // R9 sync-quantum edges ignored
    for (int j2 = 0; j2 < 2; j2++) begin
      configure(word(1, 3, 5, 4), t0);
      run_to(t0 + 3);
      hsync(c);
      run_to(c + 24 + 1 + j2);
      rx = 0; step(); rx = 1;
      run_to(c + 52);
      chk(et[0] == c + 24 && et[1] == c + 48, "R9 sync quantum edge", et[1] - c, 48);
    end

    // R9 one resync per bit
    configure(word(1, 3, 5, 4), t0);
    run_to(t0 + 3);
    hsync(c);
    run_to(c + 3); rx = 0; step(); rx = 1;
    run_to(c + 7); rx = 0; step(); rx = 1;
    run_to(c + 40);
    chk(st[0] == c + 16 && et[0] == c + 26, "R9 second edge ignored", et[0] - c, 26);

    // R6 idle return: 10 samples -> resync, 11 samples -> hard sync; P=2,S=4,T=3,N=8
    configure(word(1, 0, 3, 2), t0);
    run_to(t0 + 3);
    hsync(c);
    run_to(c + 156);
    clr(); rx = 0; step(); rx = 1;
    run_to(c + 180);
    chk(et[0] == c + 158, "R6 not yet idle", et[0] - c, 158);

    configure(word(1, 0, 3, 2), t0);
    run_to(t0 + 3);
    hsync(c);
    run_to(c + 172);
    e = cyc;
    clr(); rx = 0; step(); rx = 1;
    run_to(e + 20);
    chk(st[0] == e + 10 && et[0] == e + 16, "R6 idle after recessive run", et[0] - e, 16);

    s = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails + s);
    $finish;
  end
endmodule